// File: doc/BRIEF.md
# Inter-Processor Flag Register Bank

This block carries one-way event signalling from a sending processor core to a receiving processor core. It holds a bank of 32 single-bit flags. The sender raises flags by writing ones into a set register. The receiver lowers them by writing ones into either a clear register or an acknowledge register. The two lowering views behave the same way on the flags. Having both lets software tell "cancelled" apart from "handled" in its own protocol.

Each core has its own register port, with a select, a write enable, a byte offset, write data and read data. Both cores can read the live flag state through a status register. The four lowest flags are also driven out as level interrupt lines toward the receiving core. The other 28 flags are plain status bits that the receiver must poll.

Top module: `ipc_flag_bank`

## Requirements
- R1: The bank holds 32 flags. Flag n (1 to 32) sits at bit n-1 of every register. After a synchronous active-high reset, every flag is 0.
- R2: A sender-port write (select and write enable high) to offset 0x0 sets each flag whose data bit is 1 at the next clock edge. Data bits that are 0 leave their flags unchanged.
- R3: A receiver-port write to offset 0x4 clears each flag whose data bit is 1 at the next clock edge. Data bits that are 0 leave their flags unchanged.
- R4: A receiver-port write to offset 0x8 (acknowledge) clears each flag whose data bit is 1 at the next clock edge. Data bits that are 0 have no effect.
- R5: A selected read of offset 0xC on either port returns the current 32 flags in the same cycle, without a clock edge.
- R6: A read of offset 0x0, 0x4 or 0x8, or any read while the port's select is low, returns 0.
- R7: Writes from the wrong core are ignored: the sender writing 0x4 or 0x8, and the receiver writing 0x0.
- R8: When a set write and a clear or acknowledge write target the same bit in the same cycle, the flag ends up 1.
- R9: Interrupt output i (0 to 3) is high exactly while flag i+1 is 1. Flags 5 to 32 drive no interrupt.
- R10: Writes with the select or write enable low, writes to offset 0xC, and writes to unmapped offsets change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_sel | input | 1 | Sending-core port select |
| tx_we | input | 1 | Sending-core write enable |
| tx_addr | input | 4 | Sending-core byte offset |
| tx_wdata | input | 32 | Sending-core write data |
| tx_rdata | output | 32 | Sending-core read data |
| rx_sel | input | 1 | Receiving-core port select |
| rx_we | input | 1 | Receiving-core write enable |
| rx_addr | input | 4 | Receiving-core byte offset |
| rx_wdata | input | 32 | Receiving-core write data |
| rx_rdata | output | 32 | Receiving-core read data |
| irq | output | 4 | Level interrupts for flags 1 to 4 |

## Verification
The assertions check the following on every cycle:
- set-over-clear priority, clearing and holding in each flag cell;
- that no flag can rise without a sender write to the set offset;
- that the interrupt lines follow the low flags;
- that reads of write-only offsets return zero.

Only the bench's scenarios can show the rest. This covers the per-bit mapping across all 32 positions, the address and select decode of both ports, and the rejection of writes from the wrong core. It also covers the equivalence of the clear and acknowledge views under mixed patterns, with a bench model predicting the flags after each cycle.

// File: rtl/ipc_flag_pkg.sv
package ipc_flag_pkg;

    localparam int unsigned FLAG_CNT = 32;
    localparam int unsigned IRQ_CNT  = 4;
    localparam int unsigned ADDR_W   = 4;

    typedef logic [FLAG_CNT-1:0] flag_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        OFF_SET  = 4'h0,
        OFF_CLR  = 4'h4,
        OFF_ACK  = 4'h8,
        OFF_STAT = 4'hC
    } reg_off_e;

    typedef struct packed {
        flag_vec_t set;
        flag_vec_t clr;
        flag_vec_t ack;
    } flag_req_t;

    localparam flag_req_t REQ_NONE = '{set: '0, clr: '0, ack: '0};

    // Turn one port access into per-flag requests, honouring which core owns
    // which write view.
    function automatic flag_req_t decode_write(
        input logic              is_sender,
        input logic              sel,
        input logic              we,
        input logic [ADDR_W-1:0] addr,
        input flag_vec_t         wdata
    );
        flag_req_t r;
        r = REQ_NONE;
        if (sel && we) begin
            if (is_sender && addr == OFF_SET) r.set = wdata;
            if (!is_sender && addr == OFF_CLR) r.clr = wdata;
            if (!is_sender && addr == OFF_ACK) r.ack = wdata;
        end
        return r;
    endfunction

endpackage

// File: rtl/ipc_port_decode.sv
module ipc_port_decode
    import ipc_flag_pkg::*;
#(
    parameter bit IS_SENDER = 1'b0
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  flag_vec_t         wdata,
    input  flag_vec_t         flags,
    output flag_vec_t         rdata,
    output flag_req_t         req
);

    always_comb begin
        req = decode_write(IS_SENDER, sel, we, addr, wdata);
    end

    // Only the status view returns data; the write-only views read as zero.
    always_comb begin
        rdata = '0;
        if (sel && addr == OFF_STAT) rdata = flags;
    end

endmodule

// File: rtl/ipc_flag_cell.sv
module ipc_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic ack_i,
    output logic q_o
);

    logic q_r;

    always_ff @(posedge clk) begin
        if (rst)        q_r <= 1'b0;
        else if (set_i) q_r <= 1'b1;
        else if (clr_i || ack_i) q_r <= 1'b0;
    end

    assign q_o = q_r;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);

    // R3
    lower_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_i && (clr_i || ack_i)) |=> !q_o);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i && !ack_i) |=> $stable(q_o));

endmodule

// File: rtl/ipc_flag_bank.sv
module ipc_flag_bank
    import ipc_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_sel,
    input  logic              tx_we,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic [FLAG_CNT-1:0] tx_wdata,
    output logic [FLAG_CNT-1:0] tx_rdata,
    input  logic              rx_sel,
    input  logic              rx_we,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [FLAG_CNT-1:0] rx_wdata,
    output logic [FLAG_CNT-1:0] rx_rdata,
    output logic [IRQ_CNT-1:0]  irq
);

    flag_vec_t flags;
    flag_req_t tx_req;
    flag_req_t rx_req;
    flag_req_t all_req;

    ipc_port_decode #(.IS_SENDER(1'b1)) u_tx_port (
        .sel   (tx_sel),
        .we    (tx_we),
        .addr  (tx_addr),
        .wdata (tx_wdata),
        .flags (flags),
        .rdata (tx_rdata),
        .req   (tx_req)
    );

    ipc_port_decode #(.IS_SENDER(1'b0)) u_rx_port (
        .sel   (rx_sel),
        .we    (rx_we),
        .addr  (rx_addr),
        .wdata (rx_wdata),
        .flags (flags),
        .rdata (rx_rdata),
        .req   (rx_req)
    );

    always_comb begin
        all_req.set = tx_req.set | rx_req.set;
        all_req.clr = tx_req.clr | rx_req.clr;
        all_req.ack = tx_req.ack | rx_req.ack;
    end

    for (genvar g = 0; g < FLAG_CNT; g++) begin : g_flag
        ipc_flag_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .set_i (all_req.set[g]),
            .clr_i (all_req.clr[g]),
            .ack_i (all_req.ack[g]),
            .q_o   (flags[g])
        );
    end

    assign irq = flags[IRQ_CNT-1:0];

    // R7
    rise_needs_set_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_sel && tx_we && tx_addr == OFF_SET) |=> ((flags & ~$past(flags)) == '0));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (irq & ~$past(irq)) != '0 |-> $past(tx_sel && tx_we && tx_addr == OFF_SET));

    // R6
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_addr != OFF_STAT || !tx_sel) |-> tx_rdata == '0);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rx_sel && rx_addr == OFF_STAT) -> rx_rdata == '0);

endmodule

// File: tb/ipc_flag_bank_test.sv
module ipc_flag_bank_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        tx_sel, tx_we, rx_sel, rx_we;
    logic [3:0]  tx_addr, rx_addr;
    logic [31:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
    logic [3:0]  irq;
    logic [31:0] exp_flags;
    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ipc_flag_bank uut (
        .clk(clk), .rst(rst),
        .tx_sel(tx_sel), .tx_we(tx_we), .tx_addr(tx_addr),
        .tx_wdata(tx_wdata), .tx_rdata(tx_rdata),
        .rx_sel(rx_sel), .rx_we(rx_we), .rx_addr(rx_addr),
        .rx_wdata(rx_wdata), .rx_rdata(rx_rdata),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        tx_sel = 0; tx_we = 0; tx_addr = 4'h0; tx_wdata = '0;
        rx_sel = 0; rx_we = 0; rx_addr = 4'h0; rx_wdata = '0;
    endtask

    // Read status from both ports and compare flags and interrupts.
    task automatic check_state(input string req);
        idle();
        tx_sel = 1; tx_addr = 4'hC;
        rx_sel = 1; rx_addr = 4'hC;
        #1;
        chk({req, " status via tx"}, tx_rdata, exp_flags);
        chk({req, " status via rx"}, rx_rdata, exp_flags);
        chk({req, " / R9 irq"}, {28'd0, irq}, {28'd0, exp_flags[3:0]});
        idle();
    endtask

    // One access cycle on both ports; the model follows the requirements.
    task automatic cycle(input logic ts, input logic tw, input logic [3:0] ta, input logic [31:0] td,
                         input logic rs, input logic rw, input logic [3:0] ra, input logic [31:0] rd,
                         input string req);
        logic [31:0] s, c;
        tx_sel = ts; tx_we = tw; tx_addr = ta; tx_wdata = td;
        rx_sel = rs; rx_we = rw; rx_addr = ra; rx_wdata = rd;
        s = (ts && tw && ta == 4'h0) ? td : 32'h0;
        c = (rs && rw && (ra == 4'h4 || ra == 4'h8)) ? rd : 32'h0;
        @(posedge clk); #1;
        exp_flags = (exp_flags & ~c) | s;
        check_state(req);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        exp_flags = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        check_state("R1 reset");

        // R2 / R1: walking set, one bit per flag position
        for (int i = 0; i < 32; i++)
            cycle(1, 1, 4'h0, 32'h1 << i, 0, 0, 4'h0, 0, "R1 R2 walking set");

        // R6: write-only offsets and unselected reads return zero
        for (int a = 0; a < 3; a++) begin
            tx_sel = 1; rx_sel = 1; tx_addr = 4'(a * 4); rx_addr = 4'(a * 4);
            #1;
            chk("R6 tx write-only read", tx_rdata, 0);
            chk("R6 rx write-only read", rx_rdata, 0);
            idle();
        end
        tx_addr = 4'hC; rx_addr = 4'hC; #1;
        chk("R6 unselected tx read", tx_rdata, 0);
        chk("R6 unselected rx read", rx_rdata, 0);
        idle();

        // R7: wrong-core writes
        cycle(1, 1, 4'h4, 32'hFFFF_FFFF, 0, 0, 4'h0, 0, "R7 sender clear");
        cycle(1, 1, 4'h8, 32'hFFFF_FFFF, 0, 0, 4'h0, 0, "R7 sender ack");

        // R4: walking acknowledge
        for (int i = 0; i < 32; i += 2)
            cycle(0, 0, 4'h0, 0, 1, 1, 4'h8, 32'h1 << i, "R4 walking ack");
        // R3: walking clear
        for (int i = 1; i < 32; i += 2)
            cycle(0, 0, 4'h0, 0, 1, 1, 4'h4, 32'h1 << i, "R3 walking clear");
        chk("R3 R4 all lowered", exp_flags, 0);

        cycle(0, 0, 4'h0, 0, 1, 1, 4'h0, 32'hFFFF_FFFF, "R7 receiver set");

        // R10: disabled and unmapped writes
        cycle(1, 0, 4'h0, 32'hFFFF_FFFF, 0, 0, 4'h0, 0, "R10 we low");
        cycle(0, 1, 4'h0, 32'hFFFF_FFFF, 0, 0, 4'h0, 0, "R10 sel low");
        cycle(1, 1, 4'hC, 32'hFFFF_FFFF, 0, 0, 4'h0, 0, "R10 status write");
        cycle(1, 1, 4'h2, 32'hFFFF_FFFF, 0, 0, 4'h0, 0, "R10 unmapped");

        // R8: same-cycle collision on every bit
        cycle(1, 1, 4'h0, 32'hA5A5_A5A5, 0, 0, 4'h0, 0, "R8 preload");
        for (int i = 0; i < 32; i++)
            cycle(1, 1, 4'h0, 32'h1 << i, 1, 1, (i % 2) ? 4'h4 : 4'h8, 32'hFFFF_FFFF, "R8 set wins");

        // R2 R3 R4: mixed pseudo-random patterns, zeros must not disturb
        for (int k = 0; k < 200; k++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            cycle(1, 1, 4'h0, a, 1, 1, (k % 2) ? 4'h4 : 4'h8, b, "R2 R3 R4 mixed");
        end

        // R5: status visible in the same cycle after a rise
        cycle(0, 0, 4'h0, 0, 1, 1, 4'h4, 32'hFFFF_FFFF, "R5 clear all");
        cycle(1, 1, 4'h0, 32'h8000_0010, 0, 0, 4'h0, 0, "R5 R9 high flags no irq");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule